// File: doc/BRIEF.md
# USB Bulk OUT Receive Buffer Controller

This block runs the receive side of one device-mode bulk OUT endpoint. A packet front end reports each incoming packet with a start strobe, one strobe per received byte, and an end strobe that carries a bad-status flag (for example a CRC failure). The block counts the bytes and decides how to answer the host. It keeps the byte count of up to two held packets in arrival order, and it tells the consumer when the oldest packet can be unloaded. The byte storage itself sits outside the block.

The consumer is either software or a DMA engine. When DMA is off, a held packet shows as packet-ready and raises the interrupt, and software frees the buffer with a release strobe. When DMA is on, a level request stays high while any packet is held, and each acknowledge frees one buffer. In this mode only errors raise the interrupt. A single enable masks the interrupt output.

Top module: `usb_bulk_rx_ctrl`

## Requirements
- R1: After reset no packet is held. `pkt_rdy`, `dma_req`, `irq`, `err_flag` and `hs_valid` are all 0.
- R2: For a good packet of at most MAX_PKT bytes that finds a free buffer, `hs_valid`=1 and `hs_nak`=0 in the cycle after `rx_end`. One cycle later `rd_count` shows its byte count (0 is allowed) and `pkt_rdy`=1.
- R3: With `cfg_dbuf_en`=0 only one packet is held. A good packet that starts while it is held is answered with `hs_valid`=1, `hs_nak`=1, and it is discarded.
- R4: With `cfg_dbuf_en`=1 two packets can be held. A third good packet is NAKed. Packets are presented on `rd_count` oldest first.
- R5: A packet that ends with `rx_bad`=1 gives no handshake (`hs_valid` stays 0) and takes no buffer. One cycle after the handshake slot it sets `err_flag`.
- R6: A packet with more than MAX_PKT byte strobes is handled like a bad packet (no handshake, no buffer, `err_flag` set).
- R7: With `cfg_dma_en`=0, `irq` is high while a packet is held (when unmasked). `sw_release` frees the oldest packet. `dma_ack` has no effect.
- R8: With `cfg_dma_en`=1, `dma_req` is high exactly while a packet is held and no packet raises `irq`. `dma_ack` frees the oldest packet. `sw_release` has no effect.
- R9: `err_flag` raises `irq` in both consumer modes. `err_clr` clears it. When a new error arrives in the same cycle as `err_clr`, the flag stays set.
- R10: With `cfg_irq_en`=0, `irq` stays 0 while the status flags still update.
- R11: When a packet is committed in the same cycle the oldest one is released, the number held does not change. The new packet becomes the oldest one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbuf_en | input | 1 | Allow two held packets |
| cfg_dma_en | input | 1 | Consumer is the DMA engine |
| cfg_irq_en | input | 1 | Interrupt output enable |
| rx_start | input | 1 | First cycle of an incoming packet |
| rx_byte | input | 1 | One payload byte received |
| rx_end | input | 1 | Packet finished |
| rx_bad | input | 1 | Status with `rx_end`: packet corrupt |
| hs_valid | output | 1 | Handshake decision valid |
| hs_nak | output | 1 | Handshake is NAK (else ACK) |
| rd_count | output | $clog2(MAX_PKT+1) | Byte count of the oldest held packet |
| pkt_rdy | output | 1 | At least one packet held |
| sw_release | input | 1 | Software frees the oldest packet |
| dma_req | output | 1 | DMA request level |
| dma_ack | input | 1 | DMA finished unloading the oldest packet |
| err_flag | output | 1 | Error status |
| err_clr | input | 1 | Clear the error status |
| irq | output | 1 | Endpoint interrupt |

## Verification
Two pairs of events can fall on the same clock edge. A packet commit can coincide with the release of the oldest packet. An error event can coincide with a software error clear. The bench forces both pairs by raising `sw_release` or `err_clr` in the cycle between the handshake and the commit edge. It then judges the result from the ports. For the first pair, `pkt_rdy` must stay 1, `rd_count` must move to the new packet, and one more release must empty the block. For the second pair, `err_flag` must remain set.

// File: rtl/usb_bulk_rx_pkg.sv
package usb_bulk_rx_pkg;

    typedef enum logic [1:0] {
        EVT_ACK = 2'd0,
        EVT_NAK = 2'd1,
        EVT_ERR = 2'd2
    } evt_kind_e;

    typedef struct packed {
        logic      valid;
        evt_kind_e kind;
    } rx_evt_t;

    function automatic int unsigned count_width(input int unsigned max_pkt);
        return $clog2(max_pkt + 1);
    endfunction

    function automatic int unsigned slot_cap(input logic dbuf, input int unsigned slots);
        return dbuf ? slots : 1;
    endfunction

endpackage

// File: rtl/usb_bulk_rx_capture.sv
module usb_bulk_rx_capture
    import usb_bulk_rx_pkg::*;
#(
    parameter int unsigned MAX_PKT = 512,
    parameter int unsigned CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_byte,
    input  logic             rx_end,
    input  logic             rx_bad,
    input  logic             has_room,
    output rx_evt_t          evt_o,
    output logic [CNT_W-1:0] evt_cnt_o
);

    logic             busy_q;
    logic             accept_q;
    logic             ovf_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            accept_q  <= 1'b0;
            ovf_q     <= 1'b0;
            cnt_q     <= '0;
            evt_o     <= '{valid: 1'b0, kind: EVT_ACK};
            evt_cnt_o <= '0;
        end else begin
            evt_o.valid <= 1'b0;
            if (rx_start) begin
                busy_q   <= 1'b1;
                accept_q <= has_room;
                ovf_q    <= 1'b0;
                cnt_q    <= '0;
            end else if (busy_q && rx_end) begin
                busy_q      <= 1'b0;
                evt_o.valid <= 1'b1;
                if (rx_bad || ovf_q)
                    evt_o.kind <= EVT_ERR;
                else if (accept_q)
                    evt_o.kind <= EVT_ACK;
                else
                    evt_o.kind <= EVT_NAK;
                evt_cnt_o <= cnt_q;
            end else if (busy_q && rx_byte) begin
                if (cnt_q == CNT_W'(MAX_PKT))
                    ovf_q <= 1'b1;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_END_GIVES_EVT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rx_end && !rx_start) |=> evt_o.valid); // R2
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt_o.valid |=> !evt_o.valid); // R2
    AST_BAD_IS_ERR: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rx_end && rx_bad && !rx_start) |=> (evt_o.kind == EVT_ERR)); // R5

endmodule

// File: rtl/usb_bulk_rx_slots.sv
module usb_bulk_rx_slots
    import usb_bulk_rx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbuf_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_cnt,
    input  logic             release_req,
    output logic             has_room,
    output logic             held_any,
    output logic [CNT_W-1:0] head_cnt
);

    localparam int unsigned PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned OCC_W = $clog2(NUM_SLOTS + 1);

    logic [CNT_W-1:0] slot_cnt [NUM_SLOTS];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             pop;
    logic             push;
    logic [OCC_W:0]   cap;
    logic [OCC_W:0]   demand;

    assign pop      = release_req && (occ != '0);
    assign push     = commit && ((occ < OCC_W'(NUM_SLOTS)) || pop);
    assign held_any = (occ != '0);
    assign head_cnt = slot_cnt[rd_ptr];
    assign cap      = (OCC_W+1)'(slot_cap(dbuf_en, NUM_SLOTS));
    assign demand   = {1'b0, occ} + {{OCC_W{1'b0}}, commit};
    assign has_room = (demand < cap);

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_cnt[g] <= '0;
            else if (push && (wr_ptr == PTR_W'(g)))
                slot_cnt[g] <= commit_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (commit && !pop) |-> (occ < OCC_W'(NUM_SLOTS))); // R4
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (commit && !pop && !dbuf_en && $stable(dbuf_en)) |-> (occ == '0)); // R3
    AST_SWAP_KEEPS_OCC: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(occ)); // R11

endmodule

// File: rtl/usb_bulk_rx_notify.sv
module usb_bulk_rx_notify (
    input  logic clk,
    input  logic rst,
    input  logic dma_en,
    input  logic irq_en,
    input  logic held_any,
    input  logic err_evt,
    input  logic err_clr,
    input  logic sw_release,
    input  logic dma_ack,
    output logic release_req,
    output logic err_flag,
    output logic irq,
    output logic dma_req,
    output logic pkt_rdy
);

    always_ff @(posedge clk) begin
        if (rst)
            err_flag <= 1'b0;
        else if (err_evt)
            err_flag <= 1'b1;
        else if (err_clr)
            err_flag <= 1'b0;
    end

    assign release_req = dma_en ? dma_ack : sw_release;
    assign dma_req     = dma_en && held_any;
    assign pkt_rdy     = held_any;
    assign irq         = irq_en && (err_flag || (!dma_en && held_any));

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> err_flag); // R9
    AST_DMA_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dma_en && !err_flag) |-> !irq); // R8
    AST_REQ_DROP_ACK: assert property (@(posedge clk) disable iff (rst)
        (dma_en && $past(dma_en) && $fell(dma_req)) |-> $past(dma_ack)); // R8

endmodule

// File: rtl/usb_bulk_rx_ctrl.sv
module usb_bulk_rx_ctrl
    import usb_bulk_rx_pkg::*;
#(
    parameter int unsigned MAX_PKT   = 512,
    parameter int unsigned NUM_SLOTS = 2,
    localparam int unsigned CNT_W    = count_width(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dbuf_en,
    input  logic             cfg_dma_en,
    input  logic             cfg_irq_en,
    input  logic             rx_start,
    input  logic             rx_byte,
    input  logic             rx_end,
    input  logic             rx_bad,
    output logic             hs_valid,
    output logic             hs_nak,
    output logic [CNT_W-1:0] rd_count,
    output logic             pkt_rdy,
    input  logic             sw_release,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic             err_flag,
    input  logic             err_clr,
    output logic             irq
);

    rx_evt_t          evt;
    logic [CNT_W-1:0] evt_cnt;
    logic             has_room;
    logic             held_any;
    logic             release_req;
    logic             commit;
    logic             err_evt;

    assign commit   = evt.valid && (evt.kind == EVT_ACK);
    assign err_evt  = evt.valid && (evt.kind == EVT_ERR);
    assign hs_valid = evt.valid && (evt.kind != EVT_ERR);
    assign hs_nak   = evt.valid && (evt.kind == EVT_NAK);

    usb_bulk_rx_capture #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) capture_i (
        .clk       (clk),
        .rst       (rst),
        .rx_start  (rx_start),
        .rx_byte   (rx_byte),
        .rx_end    (rx_end),
        .rx_bad    (rx_bad),
        .has_room  (has_room),
        .evt_o     (evt),
        .evt_cnt_o (evt_cnt)
    );

    usb_bulk_rx_slots #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) slots_i (
        .clk         (clk),
        .rst         (rst),
        .dbuf_en     (cfg_dbuf_en),
        .commit      (commit),
        .commit_cnt  (evt_cnt),
        .release_req (release_req),
        .has_room    (has_room),
        .held_any    (held_any),
        .head_cnt    (rd_count)
    );

    usb_bulk_rx_notify notify_i (
        .clk         (clk),
        .rst         (rst),
        .dma_en      (cfg_dma_en),
        .irq_en      (cfg_irq_en),
        .held_any    (held_any),
        .err_evt     (err_evt),
        .err_clr     (err_clr),
        .sw_release  (sw_release),
        .dma_ack     (dma_ack),
        .release_req (release_req),
        .err_flag    (err_flag),
        .irq         (irq),
        .dma_req     (dma_req),
        .pkt_rdy     (pkt_rdy)
    );

    AST_BAD_NO_HS: assert property (@(posedge clk) disable iff (rst)
        (rx_end && rx_bad && !rx_start) |=> !hs_nak); // R5
    AST_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_irq_en && $past(!cfg_irq_en)) |-> !irq); // R10

endmodule

// File: tb/usb_bulk_rx_ctrl_tb_top.sv
module usb_bulk_rx_ctrl_tb_top;

    localparam int MAX = 16;
    localparam int CW  = $clog2(MAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_dbuf_en = 1'b0, cfg_dma_en = 1'b0, cfg_irq_en = 1'b1;
    logic rx_start = 1'b0, rx_byte = 1'b0, rx_end = 1'b0, rx_bad = 1'b0;
    logic sw_release = 1'b0, dma_ack = 1'b0, err_clr = 1'b0;
    logic hs_valid, hs_nak, pkt_rdy, dma_req, err_flag, irq;
    logic [CW-1:0] rd_count;

    int tests = 0;
    int fails = 0;
    logic got_hsv, got_hsn;

    always #2.5 clk = ~clk;

    usb_bulk_rx_ctrl #(.MAX_PKT(MAX), .NUM_SLOTS(2)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_dbuf_en(cfg_dbuf_en), .cfg_dma_en(cfg_dma_en), .cfg_irq_en(cfg_irq_en),
        .rx_start(rx_start), .rx_byte(rx_byte), .rx_end(rx_end), .rx_bad(rx_bad),
        .hs_valid(hs_valid), .hs_nak(hs_nak), .rd_count(rd_count), .pkt_rdy(pkt_rdy),
        .sw_release(sw_release), .dma_req(dma_req), .dma_ack(dma_ack),
        .err_flag(err_flag), .err_clr(err_clr), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one packet; optionally raises a release or error clear on the commit edge.
    task automatic send(input int len, input logic bad, input logic rel, input logic clr);
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_byte = 1'b1;
            @(negedge clk);
        end
        rx_byte = 1'b0;
        rx_end  = 1'b1;
        rx_bad  = bad;
        @(negedge clk);
        rx_end  = 1'b0;
        rx_bad  = 1'b0;
        got_hsv = hs_valid;
        got_hsn = hs_nak;
        if (rel) begin
            sw_release = !cfg_dma_en;
            dma_ack    = cfg_dma_en;
        end
        err_clr = clr;
        @(negedge clk);
        sw_release = 1'b0;
        dma_ack    = 1'b0;
        err_clr    = 1'b0;
    endtask

    task automatic pulse_rel(input logic sw, input logic dma);
        @(negedge clk);
        sw_release = sw;
        dma_ack    = dma;
        @(negedge clk);
        sw_release = 1'b0;
        dma_ack    = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!pkt_rdy && !dma_req && !irq && !err_flag && !hs_valid, "R1",
            {pkt_rdy, dma_req, irq, err_flag, hs_valid}, 0);

        for (int cfg = 0; cfg < 4; cfg++) begin
            cfg_dbuf_en = cfg[0];
            cfg_dma_en  = cfg[1];
            for (int len = 0; len <= MAX + 1; len++) begin
                int len2;
                len2 = (len + 5) % (MAX + 1);
                send(len, 1'b0, 1'b0, 1'b0);
                if (len > MAX) begin
                    chk(!got_hsv, "R6", got_hsv, 0);
                    chk(err_flag && !pkt_rdy, "R6", {err_flag, pkt_rdy}, 2);
                    chk(irq, "R9", irq, 1);
                    pulse_clr();
                    chk(!err_flag && !irq, "R9", {err_flag, irq}, 0);
                    continue;
                end
                chk(got_hsv && !got_hsn, "R2", {got_hsv, got_hsn}, 2);
                chk(rd_count == CW'(len) && pkt_rdy, "R2", rd_count, len);
                chk(dma_req == cfg_dma_en, "R8", dma_req, cfg_dma_en);
                chk(irq == !cfg_dma_en, cfg_dma_en ? "R8" : "R7", irq, !cfg_dma_en);
                send(len2, 1'b0, 1'b0, 1'b0);
                if (cfg_dbuf_en) begin
                    chk(got_hsv && !got_hsn, "R4", {got_hsv, got_hsn}, 2);
                    send(3, 1'b0, 1'b0, 1'b0);
                    chk(got_hsv && got_hsn, "R4", {got_hsv, got_hsn}, 3);
                end else begin
                    chk(got_hsv && got_hsn, "R3", {got_hsv, got_hsn}, 3);
                end
                chk(rd_count == CW'(len), "R4", rd_count, len);
                pulse_rel(cfg_dma_en, !cfg_dma_en);
                chk(pkt_rdy && rd_count == CW'(len), cfg_dma_en ? "R8" : "R7", rd_count, len);
                pulse_rel(!cfg_dma_en, cfg_dma_en);
                if (cfg_dbuf_en) begin
                    chk(pkt_rdy && rd_count == CW'(len2), "R4", rd_count, len2);
                    pulse_rel(!cfg_dma_en, cfg_dma_en);
                end
                chk(!pkt_rdy && !dma_req && !irq, cfg_dma_en ? "R8" : "R7",
                    {pkt_rdy, dma_req, irq}, 0);
            end
        end

        // R5 bad packet while one is held, in DMA mode: error still interrupts
        cfg_dbuf_en = 1'b1;
        cfg_dma_en  = 1'b1;
        send(7, 1'b0, 1'b0, 1'b0);
        send(4, 1'b1, 1'b0, 1'b0);
        chk(!got_hsv, "R5", got_hsv, 0);
        chk(err_flag && irq, "R9", {err_flag, irq}, 3);
        pulse_rel(1'b0, 1'b1);
        chk(!pkt_rdy && !dma_req, "R5", {pkt_rdy, dma_req}, 0);

        // R9 error set and clear in the same cycle: set wins
        send(2, 1'b1, 1'b0, 1'b1);
        chk(err_flag, "R9", err_flag, 1);
        pulse_clr();
        chk(!err_flag, "R9", err_flag, 0);

        // R10 mask
        cfg_dma_en = 1'b0;
        cfg_irq_en = 1'b0;
        send(9, 1'b0, 1'b0, 1'b0);
        send(1, 1'b1, 1'b0, 1'b0);
        chk(!irq && pkt_rdy && err_flag, "R10", {irq, pkt_rdy, err_flag}, 3);
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk(irq, "R10", irq, 1);
        pulse_clr();
        pulse_rel(1'b1, 1'b0);

        // R11 commit and release on the same edge
        send(6, 1'b0, 1'b0, 1'b0);
        send(11, 1'b0, 1'b1, 1'b0);
        chk(got_hsv && !got_hsn, "R11", {got_hsv, got_hsn}, 2);
        chk(pkt_rdy && rd_count == CW'(11), "R11", rd_count, 11);
        pulse_rel(1'b1, 1'b0);
        chk(!pkt_rdy, "R11", pkt_rdy, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule